// File: doc/BRIEF.md
# Cluster Cache Line Coherence Controller

This block keeps the coherence state of every line of a direct-mapped, write-back secondary cache that the processors of one cluster share. It accepts local read and write requests from its processor, snooped read and invalidate transactions from the cluster bus, and refill responses from the memory side. For each transaction it works out the next line state. It also emits invalidate or update broadcasts, a write-back request when a dirty victim is evicted, and a notify pulse that tells the inter-cluster memory processor about a write it must forward.

Every line carries one of five states. These are invalid, exclusive-dirty, locally-shared-clean, locally-shared-dirty and globally-shared-clean. A locally shared line has copies only inside this cluster, so writes to it are settled on the cluster bus alone. A globally shared line may have copies in other clusters, so writes to it raise the notify pulse. Each line also keeps a protocol bit, write-invalidate or write-update. The bit is captured from the request when the line is refilled. Tag, state and protocol bit sit in a small register file inside the block.

Local requests use a valid/ready handshake. A request must hold `req_valid` and its payload stable until `req_ready` is seen high at a clock edge. A snoop has no ready signal and is always taken in the cycle it is presented. While a snoop is present, `req_ready` and `fill_rsp_ready` are low. The write-back request `wb_valid` stays high, with `wb_addr` stable, until `wb_ready`. A refill response is held on `fill_rsp_valid` until `fill_rsp_ready`. The event, broadcast, supply and notify outputs are single-cycle pulses with no back-pressure.

Top module: `ccl_coh_ctrl`

## Requirements
- R1: After reset every line is invalid, `req_ready` is high, and `wb_valid`, `fill_req`, `evt_valid`, `bc_valid`, `snp_supply` and `mp_notify` are low.
- R2: Each completed transaction produces exactly one `evt_valid` pulse in the cycle after its accepting edge. The pulse carries the line index and the resulting state, coded 0 invalid, 1 exclusive-dirty, 2 locally-shared-clean, 3 locally-shared-dirty, 4 globally-shared-clean. `evt_snoop` is 1 for snoops and `evt_hit` is 1 on a tag hit.
- R3: A local read that hits leaves the state unchanged and raises no broadcast and no notify.
- R4: A local write that hits an exclusive-dirty line leaves it exclusive-dirty, with no broadcast and no notify.
- R5: A local write that hits a locally shared line (state 2 or 3) in invalidate mode broadcasts an invalidate (`bc_upd`=0) and moves the line to exclusive-dirty, with no notify.
- R6: A local write that hits a locally shared line in update mode broadcasts an update (`bc_upd`=1) carrying the write address and data, and the line becomes locally-shared-dirty, with no notify.
- R7: A local write that hits a globally-shared-clean line broadcasts according to the mode and raises `mp_notify`. In invalidate mode the line becomes exclusive-dirty. In update mode it stays globally-shared-clean.
- R8: The protocol bit of a line is taken from `req_upd` only at refill. On a hit, `req_upd` has no effect.
- R9: On a miss the line is refilled with the new tag. The state installed depends on `fill_rsp_src`. With bit 1 set it is globally-shared-clean. With bit 1 clear and bit 0 set it is locally-shared-clean. With both clear it is exclusive-dirty for a write and locally-shared-clean for a read. For a write, the R4 to R7 rules are then applied to the installed state.
- R10: A miss whose victim is dirty (state 1 or 3) first raises `wb_valid` with the victim's address and only then `fill_req`. A miss on a clean or invalid victim raises `fill_req` directly.
- R11: A snooped invalidate that hits a valid line makes it invalid. A snoop whose tag misses changes no line.
- R12: A snooped read that hits a dirty line (state 1 or 3) pulses `snp_supply` and leaves the line locally-shared-dirty. Hits on clean lines supply nothing and keep their state.
- R13: In a cycle with a snoop, the snoop is the one transaction handled. `req_ready` and `fill_rsp_ready` are low, and the local request or refill is taken in a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Local request present |
| req_ready | output | 1 | Local request accepted at this edge |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | TAG_W+log2(LINES) | Request address, tag above index |
| req_wdata | input | DATA_W | Write word |
| req_upd | input | 1 | Page protocol: 1 update, 0 invalidate |
| snp_valid | input | 1 | Snooped bus transaction present |
| snp_inv | input | 1 | 1 invalidate, 0 read |
| snp_addr | input | TAG_W+log2(LINES) | Snooped address |
| wb_valid | output | 1 | Dirty victim write-back request |
| wb_ready | input | 1 | Write-back taken |
| wb_addr | output | TAG_W+log2(LINES) | Victim address |
| fill_req | output | 1 | Refill request pending |
| fill_addr | output | TAG_W+log2(LINES) | Refill address |
| fill_rsp_valid | input | 1 | Refill response present |
| fill_rsp_ready | output | 1 | Refill response taken |
| fill_rsp_src | input | 2 | Where the data came from and whether there are sharers |
| evt_valid | output | 1 | Transaction completed |
| evt_snoop | output | 1 | Completed transaction was a snoop |
| evt_hit | output | 1 | Completed transaction hit |
| evt_idx | output | log2(LINES) | Line index affected |
| evt_state | output | 3 | Resulting line state |
| snp_supply | output | 1 | Line supplies data to a snooped read |
| bc_valid | output | 1 | Cluster bus broadcast |
| bc_upd | output | 1 | 1 update, 0 invalidate |
| bc_addr | output | TAG_W+log2(LINES) | Broadcast address |
| bc_data | output | DATA_W | Update word |
| mp_notify | output | 1 | Write must be forwarded to the inter-cluster memory processor |

## Verification
Every pulse output (`evt_*`, `bc_*`, `snp_supply`, `mp_notify`) is registered and is due in the cycle after the edge that accepts the request, snoop or refill. `wb_valid` and `fill_req` follow the internal phase, which changes at the accepting edge. So a dirty miss shows `wb_valid` in the next cycle and `fill_req` one cycle after `wb_ready`, while a clean miss shows `fill_req` in the next cycle. The bench drives inputs on the falling edge and samples exactly one falling edge after each accepting rising edge. A bench-side state model predicts the expected values and is stepped only when the bench performs a handshake. The sweep covers every starting state, both protocol modes, every line and every refill source, under local read, local write, snoop read, snoop invalidate, tag-missing snoop and both kinds of miss.

// File: rtl/ccl_pkg.sv
package ccl_pkg;

  // Line coherence states; the numeric codes are visible on evt_state.
  typedef enum logic [2:0] {
    ST_INV = 3'd0,
    ST_EXD = 3'd1,
    ST_LSC = 3'd2,
    ST_LSD = 3'd3,
    ST_GSC = 3'd4
  } line_st_e;

  // Outcome of applying a local write to a line.
  typedef struct packed {
    line_st_e nxt;
    logic     bcast;
    logic     bc_upd;
    logic     notify;
  } wr_res_t;

endpackage

// File: rtl/ccl_line_store.sv
module ccl_line_store import ccl_pkg::*; #(
  parameter int LINES = 4,
  parameter int TAG_W = 4,
  parameter int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [TAG_W-1:0] wtag,
  input  line_st_e         wst,
  input  logic             wupd,
  input  logic [IDX_W-1:0] ra_idx,
  output logic [TAG_W-1:0] ra_tag,
  output line_st_e         ra_st,
  output logic             ra_upd,
  input  logic [IDX_W-1:0] rb_idx,
  output logic [TAG_W-1:0] rb_tag,
  output line_st_e         rb_st,
  output logic             rb_upd
);

  line_st_e         st_arr  [LINES];
  logic [TAG_W-1:0] tag_arr [LINES];
  logic             upd_arr [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    line_st_e         st_r;
    logic [TAG_W-1:0] tag_r;
    logic             upd_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_r  <= ST_INV;
        tag_r <= '0;
        upd_r <= 1'b0;
      end else if (we && widx == IDX_W'(g)) begin
        st_r  <= wst;
        tag_r <= wtag;
        upd_r <= wupd;
      end
    end

    assign st_arr[g]  = st_r;
    assign tag_arr[g] = tag_r;
    assign upd_arr[g] = upd_r;
  end

  // Port A serves the local side, port B the snoop side.
  assign ra_tag = tag_arr[ra_idx];
  assign ra_st  = st_arr[ra_idx];
  assign ra_upd = upd_arr[ra_idx];
  assign rb_tag = tag_arr[rb_idx];
  assign rb_st  = st_arr[rb_idx];
  assign rb_upd = upd_arr[rb_idx];

endmodule

// File: rtl/ccl_rules.sv
module ccl_rules import ccl_pkg::*; (
  input  line_st_e   wr_base,
  input  logic       wr_upd,
  output wr_res_t    wr_res,
  input  logic [1:0] fill_src,
  input  logic       fill_is_wr,
  output line_st_e   fill_base,
  input  line_st_e   snp_cur,
  input  logic       snp_inv,
  output line_st_e   snp_nxt,
  output logic       snp_sup
);

  // Local write applied to a line already holding the data.
  always_comb begin
    wr_res = '{nxt: ST_EXD, bcast: 1'b0, bc_upd: 1'b0, notify: 1'b0};
    case (wr_base)
      ST_LSC, ST_LSD: begin
        wr_res.bcast  = 1'b1;
        wr_res.bc_upd = wr_upd;
        wr_res.nxt    = wr_upd ? ST_LSD : ST_EXD;
      end
      ST_GSC: begin
        wr_res.bcast  = 1'b1;
        wr_res.bc_upd = wr_upd;
        wr_res.notify = 1'b1;
        wr_res.nxt    = wr_upd ? ST_GSC : ST_EXD;
      end
      default: wr_res.nxt = ST_EXD;
    endcase
  end

  // State a refill installs, before any pending write is applied.
  always_comb begin
    if (fill_src[1])      fill_base = ST_GSC;
    else if (fill_src[0]) fill_base = ST_LSC;
    else                  fill_base = fill_is_wr ? ST_EXD : ST_LSC;
  end

  // Snooped transaction on a hitting line.
  always_comb begin
    snp_sup = 1'b0;
    snp_nxt = snp_cur;
    if (snp_inv) begin
      snp_nxt = ST_INV;
    end else if (snp_cur == ST_EXD || snp_cur == ST_LSD) begin
      snp_sup = 1'b1;
      snp_nxt = ST_LSD;
    end
  end

endmodule

// File: rtl/ccl_coh_ctrl.sv
module ccl_coh_ctrl import ccl_pkg::*; #(
  parameter int LINES  = 4,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             req_valid,
  output logic                             req_ready,
  input  logic                             req_write,
  input  logic [TAG_W+$clog2(LINES)-1:0]   req_addr,
  input  logic [DATA_W-1:0]                req_wdata,
  input  logic                             req_upd,
  input  logic                             snp_valid,
  input  logic                             snp_inv,
  input  logic [TAG_W+$clog2(LINES)-1:0]   snp_addr,
  output logic                             wb_valid,
  input  logic                             wb_ready,
  output logic [TAG_W+$clog2(LINES)-1:0]   wb_addr,
  output logic                             fill_req,
  output logic [TAG_W+$clog2(LINES)-1:0]   fill_addr,
  input  logic                             fill_rsp_valid,
  output logic                             fill_rsp_ready,
  input  logic [1:0]                       fill_rsp_src,
  output logic                             evt_valid,
  output logic                             evt_snoop,
  output logic                             evt_hit,
  output logic [$clog2(LINES)-1:0]         evt_idx,
  output logic [2:0]                       evt_state,
  output logic                             snp_supply,
  output logic                             bc_valid,
  output logic                             bc_upd,
  output logic [TAG_W+$clog2(LINES)-1:0]   bc_addr,
  output logic [DATA_W-1:0]                bc_data,
  output logic                             mp_notify
);

  localparam int IDX_W  = $clog2(LINES);
  localparam int ADDR_W = TAG_W + IDX_W;

  typedef enum logic [1:0] {PH_IDLE, PH_WB, PH_FILL} phase_e;

  phase_e              phase_q;
  logic                pend_wr, pend_upd;
  logic [TAG_W-1:0]    pend_tag, vic_tag;
  logic [IDX_W-1:0]    pend_idx;
  logic [DATA_W-1:0]   pend_data;

  logic [IDX_W-1:0]    req_idx, snp_idx, ra_idx, widx;
  logic [TAG_W-1:0]    req_tag, snp_tag, ra_tag, rb_tag, wtag;
  line_st_e            ra_st, rb_st, fill_base, snp_nxt, st_next, wr_base;
  logic                ra_upd, rb_upd, wupd, we, snp_sup, wr_upd;
  logic                lcl_hit, snp_hit, vic_dirty;
  logic                acc, lcl_done, fill_fire, wr_apply;
  wr_res_t             wr_res;

  assign req_idx = req_addr[IDX_W-1:0];
  assign req_tag = req_addr[ADDR_W-1:IDX_W];
  assign snp_idx = snp_addr[IDX_W-1:0];
  assign snp_tag = snp_addr[ADDR_W-1:IDX_W];

  assign ra_idx  = (phase_q == PH_IDLE) ? req_idx : pend_idx;

  ccl_line_store #(.LINES(LINES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (we),
    .widx   (widx),
    .wtag   (wtag),
    .wst    (st_next),
    .wupd   (wupd),
    .ra_idx (ra_idx),
    .ra_tag (ra_tag),
    .ra_st  (ra_st),
    .ra_upd (ra_upd),
    .rb_idx (snp_idx),
    .rb_tag (rb_tag),
    .rb_st  (rb_st),
    .rb_upd (rb_upd)
  );

  // Snoop has priority: one transaction per cycle.
  assign req_ready      = (phase_q == PH_IDLE) && !snp_valid;
  assign fill_rsp_ready = (phase_q == PH_FILL) && !snp_valid;
  assign acc            = req_valid && req_ready;
  assign fill_fire      = fill_rsp_valid && fill_rsp_ready;

  assign lcl_hit   = (ra_st != ST_INV) && (ra_tag == req_tag);
  assign snp_hit   = snp_valid && (rb_st != ST_INV) && (rb_tag == snp_tag);
  assign vic_dirty = (ra_st == ST_EXD) || (ra_st == ST_LSD);
  assign lcl_done  = acc && lcl_hit;
  assign wr_apply  = (lcl_done && req_write) || (fill_fire && pend_wr);

  assign wr_base = fill_fire ? fill_base : ra_st;
  assign wr_upd  = fill_fire ? pend_upd : ra_upd;

  ccl_rules u_rules (
    .wr_base    (wr_base),
    .wr_upd     (wr_upd),
    .wr_res     (wr_res),
    .fill_src   (fill_rsp_src),
    .fill_is_wr (pend_wr),
    .fill_base  (fill_base),
    .snp_cur    (rb_st),
    .snp_inv    (snp_inv),
    .snp_nxt    (snp_nxt),
    .snp_sup    (snp_sup)
  );

  // Resulting state of whichever transaction completes this cycle.
  always_comb begin
    if (snp_valid)      st_next = snp_hit ? snp_nxt : ST_INV;
    else if (lcl_done)  st_next = req_write ? wr_res.nxt : ra_st;
    else                st_next = pend_wr ? wr_res.nxt : fill_base;
  end

  assign we   = snp_hit || (lcl_done && req_write) || fill_fire;
  assign widx = snp_valid ? snp_idx : (fill_fire ? pend_idx : req_idx);
  assign wtag = snp_valid ? rb_tag  : (fill_fire ? pend_tag : req_tag);
  assign wupd = snp_valid ? rb_upd  : (fill_fire ? pend_upd : ra_upd);

  // Miss sequencing.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      pend_wr   <= 1'b0;
      pend_upd  <= 1'b0;
      pend_tag  <= '0;
      pend_idx  <= '0;
      pend_data <= '0;
      vic_tag   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (acc && !lcl_hit) begin
          pend_wr   <= req_write;
          pend_upd  <= req_upd;
          pend_tag  <= req_tag;
          pend_idx  <= req_idx;
          pend_data <= req_wdata;
          vic_tag   <= ra_tag;
          phase_q   <= vic_dirty ? PH_WB : PH_FILL;
        end
        PH_WB:   if (wb_ready)  phase_q <= PH_FILL;
        PH_FILL: if (fill_fire) phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign wb_valid  = (phase_q == PH_WB);
  assign wb_addr   = {vic_tag, pend_idx};
  assign fill_req  = (phase_q == PH_FILL);
  assign fill_addr = {pend_tag, pend_idx};

  // Registered event and bus outputs, due one cycle after acceptance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_valid  <= 1'b0;
      evt_snoop  <= 1'b0;
      evt_hit    <= 1'b0;
      evt_idx    <= '0;
      evt_state  <= 3'd0;
      snp_supply <= 1'b0;
      bc_valid   <= 1'b0;
      bc_upd     <= 1'b0;
      bc_addr    <= '0;
      bc_data    <= '0;
      mp_notify  <= 1'b0;
    end else begin
      evt_valid  <= snp_valid || lcl_done || fill_fire;
      evt_snoop  <= snp_valid;
      evt_hit    <= snp_valid ? snp_hit : lcl_done;
      evt_idx    <= widx;
      evt_state  <= st_next;
      snp_supply <= snp_hit && snp_sup;
      bc_valid   <= wr_apply && wr_res.bcast;
      bc_upd     <= wr_apply && wr_res.bc_upd;
      mp_notify  <= wr_apply && wr_res.notify;
      bc_addr    <= fill_fire ? {pend_tag, pend_idx} : req_addr;
      bc_data    <= fill_fire ? pend_data : req_wdata;
    end
  end

endmodule

// File: rtl/ccl_coh_chk.sv
module ccl_coh_chk #(
  parameter int LINES = 4,
  parameter int TAG_W = 4
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           snp_valid,
  input logic                           snp_inv,
  input logic                           req_ready,
  input logic                           fill_rsp_ready,
  input logic                           wb_valid,
  input logic                           wb_ready,
  input logic [TAG_W+$clog2(LINES)-1:0] wb_addr,
  input logic                           fill_req,
  input logic                           evt_valid,
  input logic                           evt_snoop,
  input logic [2:0]                     evt_state,
  input logic                           snp_supply,
  input logic                           bc_valid,
  input logic                           bc_upd,
  input logic                           mp_notify
);

  // R13
  snoop_blocks_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !req_ready && !fill_rsp_ready);

  // R2
  snoop_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |=> evt_valid && evt_snoop);

  // R11
  snoop_inv_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && snp_inv |=> evt_state == 3'd0);

  // R12
  supply_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply |-> evt_snoop && evt_state == 3'd3);

  // R10
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr));

  // R10
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && wb_ready |=> fill_req && !wb_valid);

  // R7
  notify_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mp_notify |-> bc_valid);

  // R5
  inv_bcast_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bc_valid && !bc_upd |-> evt_state == 3'd1);

  // R6
  upd_bcast_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bc_valid && bc_upd |-> evt_state == 3'd3 || evt_state == 3'd4);

endmodule

bind ccl_coh_ctrl ccl_coh_chk #(.LINES(LINES), .TAG_W(TAG_W)) u_chk (.*);

// File: tb/ccl_coh_ctrl_tb.sv
module ccl_coh_ctrl_tb;

  localparam int LINES  = 4;
  localparam int TAG_W  = 4;
  localparam int DATA_W = 8;
  localparam int IDX_W  = 2;
  localparam int ADDR_W = TAG_W + IDX_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0, req_write = 1'b0, req_upd = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              snp_valid = 1'b0, snp_inv = 1'b0;
  logic [ADDR_W-1:0] snp_addr = '0;
  logic              wb_valid, wb_ready = 1'b0;
  logic [ADDR_W-1:0] wb_addr, fill_addr, bc_addr;
  logic              fill_req, fill_rsp_valid = 1'b0, fill_rsp_ready;
  logic [1:0]        fill_rsp_src = 2'd0;
  logic              evt_valid, evt_snoop, evt_hit, snp_supply;
  logic [IDX_W-1:0]  evt_idx;
  logic [2:0]        evt_state;
  logic              bc_valid, bc_upd, mp_notify;
  logic [DATA_W-1:0] bc_data;

  int n_vec = 0;
  int n_bad = 0;
  int mst  [LINES];
  int mtag [LINES];
  int mupd [LINES];

  always #5 clk = ~clk;

  ccl_coh_ctrl #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_upd(req_upd),
    .snp_valid(snp_valid), .snp_inv(snp_inv), .snp_addr(snp_addr),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr),
    .fill_req(fill_req), .fill_addr(fill_addr),
    .fill_rsp_valid(fill_rsp_valid), .fill_rsp_ready(fill_rsp_ready),
    .fill_rsp_src(fill_rsp_src),
    .evt_valid(evt_valid), .evt_snoop(evt_snoop), .evt_hit(evt_hit),
    .evt_idx(evt_idx), .evt_state(evt_state), .snp_supply(snp_supply),
    .bc_valid(bc_valid), .bc_upd(bc_upd), .bc_addr(bc_addr),
    .bc_data(bc_data), .mp_notify(mp_notify)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  // Expected effect of a local write on a line in state st (R4..R7).
  function automatic void wrule(input int st, input int upd, output int nst,
                                output int bc, output int bcu, output int nt);
    bc = 0; bcu = 0; nt = 0; nst = 1;
    if (st == 2 || st == 3) begin bc = 1; bcu = upd; nst = upd ? 3 : 1; end
    else if (st == 4)       begin bc = 1; bcu = upd; nt = 1; nst = upd ? 4 : 1; end
  endfunction

  function automatic string wlabel(input int st, input int upd);
    if (st == 1) return "R4";
    if (st == 4) return "R7";
    return upd ? "R6" : "R5";
  endfunction

  task automatic do_req(input bit wr, input int idx, input int tag, input bit upd,
                        input int data, input int src);
    int hit, addr, est, ebc, ebcu, ent, dirty, base, eupd;
    string r;
    addr = tag * LINES + idx;
    hit  = (mst[idx] != 0 && mtag[idx] == tag);
    @(negedge clk);
    chk("R13 ready idle", req_ready, 1);
    req_valid = 1'b1; req_write = wr; req_addr = ADDR_W'(addr);
    req_wdata = DATA_W'(data); req_upd = upd;
    @(negedge clk);
    req_valid = 1'b0;
    if (hit) begin
      if (wr) begin
        eupd = mupd[idx];
        wrule(mst[idx], eupd, est, ebc, ebcu, ent);
        r = {wlabel(mst[idx], eupd), " R8 write hit"};
      end else begin
        est = mst[idx]; ebc = 0; ebcu = 0; ent = 0; r = "R3 read hit";
      end
      chk({r, " evt_valid"}, evt_valid, 1);
      chk({r, " R2 evt_snoop"}, evt_snoop, 0);
      chk({r, " R2 evt_hit"}, evt_hit, 1);
      chk({r, " R2 evt_idx"}, evt_idx, idx);
      chk({r, " state"}, evt_state, est);
      chk({r, " bc_valid"}, bc_valid, ebc);
      chk({r, " mp_notify"}, mp_notify, ent);
      if (ebc != 0) begin
        chk({r, " bc_upd"}, bc_upd, ebcu);
        chk({r, " bc_addr"}, bc_addr, addr);
        chk({r, " bc_data"}, bc_data, data);
      end
      mst[idx] = est;
    end else begin
      dirty = (mst[idx] == 1 || mst[idx] == 3) ? 1 : 0;
      chk("R10 no event on miss", evt_valid, 0);
      chk("R10 wb_valid", wb_valid, dirty);
      if (dirty != 0) begin
        chk("R10 wb_addr", wb_addr, mtag[idx] * LINES + idx);
        chk("R10 fill waits", fill_req, 0);
        wb_ready = 1'b1;
        @(negedge clk);
        wb_ready = 1'b0;
      end
      chk("R10 fill_req", fill_req, 1);
      chk("R10 wb dropped", wb_valid, 0);
      chk("R9 fill_addr", fill_addr, addr);
      fill_rsp_valid = 1'b1; fill_rsp_src = 2'(src);
      #1;
      chk("R13 fill_rsp_ready", fill_rsp_ready, 1);
      @(negedge clk);
      fill_rsp_valid = 1'b0;
      if ((src & 2) != 0)      base = 4;
      else if ((src & 1) != 0) base = 2;
      else                     base = wr ? 1 : 2;
      if (wr) wrule(base, upd, est, ebc, ebcu, ent);
      else begin est = base; ebc = 0; ebcu = 0; ent = 0; end
      r = wr ? {"R9 ", wlabel(base, upd), " write fill"} : "R9 read fill";
      chk({r, " evt_valid"}, evt_valid, 1);
      chk({r, " R2 evt_hit"}, evt_hit, 0);
      chk({r, " R2 evt_idx"}, evt_idx, idx);
      chk({r, " state"}, evt_state, est);
      chk({r, " bc_valid"}, bc_valid, ebc);
      chk({r, " mp_notify"}, mp_notify, ent);
      if (ebc != 0) begin
        chk({r, " bc_upd"}, bc_upd, ebcu);
        chk({r, " bc_data"}, bc_data, data);
      end
      chk({r, " fill done"}, fill_req, 0);
      mst[idx] = est; mtag[idx] = tag; mupd[idx] = upd;
    end
  endtask

  task automatic do_snoop(input bit inv, input int idx, input int tag);
    int hit, est, sup;
    string r;
    r   = inv ? "R11 snoop inv" : "R12 snoop read";
    hit = (mst[idx] != 0 && mtag[idx] == tag) ? 1 : 0;
    sup = 0; est = mst[idx];
    if (hit != 0) begin
      if (inv) est = 0;
      else if (mst[idx] == 1 || mst[idx] == 3) begin est = 3; sup = 1; end
    end
    @(negedge clk);
    snp_valid = 1'b1; snp_inv = inv; snp_addr = ADDR_W'(tag * LINES + idx);
    #1;
    chk("R13 req blocked", req_ready, 0);
    @(negedge clk);
    snp_valid = 1'b0;
    chk({r, " R2 evt_valid"}, evt_valid, 1);
    chk({r, " R2 evt_snoop"}, evt_snoop, 1);
    chk({r, " evt_hit"}, evt_hit, hit);
    chk({r, " state"}, evt_state, (hit != 0) ? est : 0);
    chk({r, " supply"}, snp_supply, sup);
    chk({r, " no bcast"}, bc_valid, 0);
    mst[idx] = est;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog: actual=expired expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < LINES; i++) begin mst[i] = 0; mtag[i] = 0; mupd[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 req_ready", req_ready, 1);
    chk("R1 wb_valid", wb_valid, 0);
    chk("R1 fill_req", fill_req, 0);
    chk("R1 evt_valid", evt_valid, 0);
    chk("R1 bc_valid", bc_valid, 0);
    chk("R1 snp_supply", snp_supply, 0);
    chk("R1 mp_notify", mp_notify, 0);
    // R1: a read after reset misses with no write-back.
    do_req(0, 1, 7, 0, 0, 1);

    // Sweep: line x mode x starting state x operation.
    for (int idx = 0; idx < LINES; idx++) begin
      for (int upd = 0; upd < 2; upd++) begin
        for (int s = 0; s < 5; s++) begin
          for (int op = 0; op < 7; op++) begin
            int t, t2;
            t  = (idx + 2 * s + upd) % 16;
            t2 = (t + 5) % 16;
            if (mst[idx] != 0) do_snoop(1, idx, mtag[idx]);
            case (s)
              1: do_req(1, idx, t, upd[0], 8'h11, 0);
              2: do_req(0, idx, t, upd[0], 0, 1);
              3: begin do_req(1, idx, t, upd[0], 8'h22, 0); do_snoop(0, idx, t); end
              4: do_req(0, idx, t, upd[0], 0, 2);
              default: ;
            endcase
            case (op)
              0: do_req(0, idx, t, upd[0], 0, (idx + op) % 4);
              1: do_req(1, idx, t, !upd[0], idx * 16 + s * 3 + 1, (s + 1) % 4); // R8
              2: do_snoop(0, idx, t);
              3: do_snoop(1, idx, t);
              4: do_req(0, idx, t2, upd[0], 0, (s + idx) % 4);
              5: do_req(1, idx, t2, upd[0], 8'hA5 ^ (s * 7), (s + idx + 1) % 4);
              default: begin do_snoop(1, idx, t2); do_req(0, idx, t, upd[0], 0, 3); end
            endcase
          end
        end
      end
    end

    // R13: snoop and local request in the same cycle.
    if (mst[1] != 0) do_snoop(1, 1, mtag[1]);
    do_req(0, 0, 3, 0, 0, 1);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = ADDR_W'(3 * LINES + 0);
    snp_valid = 1'b1; snp_inv = 1'b0; snp_addr = ADDR_W'(15 * LINES + 1);
    #1;
    chk("R13 req held off", req_ready, 0);
    @(negedge clk);
    snp_valid = 1'b0;
    chk("R13 snoop first", evt_snoop, 1);
    chk("R13 snoop miss", evt_hit, 0);
    #1;
    chk("R13 req now ready", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R13 req done", evt_valid, 1);
    chk("R13 req local", evt_snoop, 0);
    chk("R13 req hit", evt_hit, 1);
    chk("R13 req state", evt_state, mst[0]);

    // R13: snoop and refill response in the same cycle.
    if (mst[2] != 0) do_snoop(1, 2, mtag[2]);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = ADDR_W'(9 * LINES + 2); req_upd = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R13 fill pending", fill_req, 1);
    fill_rsp_valid = 1'b1; fill_rsp_src = 2'd2;
    snp_valid = 1'b1; snp_inv = 1'b1; snp_addr = ADDR_W'(14 * LINES + 3);
    #1;
    chk("R13 fill held off", fill_rsp_ready, 0);
    @(negedge clk);
    snp_valid = 1'b0;
    chk("R13 snoop before fill", evt_snoop, 1);
    chk("R13 fill still pending", fill_req, 1);
    #1;
    chk("R13 fill now ready", fill_rsp_ready, 1);
    @(negedge clk);
    fill_rsp_valid = 1'b0;
    chk("R13 R9 fill event", evt_valid, 1);
    chk("R13 R9 fill state", evt_state, 4);
    mst[2] = 4; mtag[2] = 9; mupd[2] = 1;
    // R7: update mode on the globally shared line keeps it shared and notifies.
    do_req(1, 2, 9, 0, 8'h3C, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule